// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This block gathers the interrupt-worthy events of one DMA channel. It records them in a 12-bit sticky status register and filters them through a mask register. It drives a single level interrupt line that stays high while any event is both recorded and unmasked. Software uses a simple word-addressed register port. Status bits are cleared by writing ones to them. The mask is read-only and changes only through two command offsets: one unmasks bits and the other masks them.

Two 8-bit counters tally how many descriptor completions asked for an interrupt, one for the source side and one for the destination side. Each counter clears when it is read. If a counter wraps, an error flag is raised in the status register. Any access to an offset the unit does not decode sets a status flag and reads back zero. The datapath delivers events as single-cycle pulses.

Top module: `dma_irq_unit`

## Requirements
- R1: After synchronous reset the status register reads 0, the mask reads 0xFFF, both counters read 0 and `irq_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k, and the bit stays set until cleared. Writing offset 0 clears every status bit whose write-data bit is 1. Reads of offset 0 return zero in bits 31:12.
- R3: Writing offset 2 clears each mask bit whose write-data bit is 1. Writing offset 3 sets each mask bit whose write-data bit is 1. Offsets 2 and 3 read back as 0. A write to offset 1, where the mask reads, leaves the mask unchanged.
- R4: `irq_o` is the OR over all bits of (status AND NOT mask), taken through one register stage. It changes on the clock edge after the edge that changed status or mask.
- R5: A pulse on `src_done_i` adds one to the source counter (offset 4) and sets status bit 1. A pulse on `dst_done_i` adds one to the destination counter (offset 5) and sets status bit 2.
- R6: A counter that increments from 255 wraps to 0. The wrap sets status bit 4 for the source counter and status bit 5 for the destination counter.
- R7: Reading offset 4 or 5 returns the counter value and clears that counter to 0. Writes to offsets 4 and 5 have no effect.
- R8: Any access, read or write, to offsets 6 to 15 sets status bit 0, and a read there returns 0.
- R9: If an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R10: If a counter is read in the same cycle that it increments, the read returns the old value and the counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| evt_i | input | ST_W | One-cycle event pulses, one per status bit |
| src_done_i | input | 1 | Source descriptor completion that requests an interrupt |
| dst_done_i | input | 1 | Destination descriptor completion that requests an interrupt |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 4 address bits, a 12-bit status register and 8-bit counters. With these values every event bit, every mask bit and all ten undecoded offsets can be swept one by one. The counters can be driven through a full 256-step wrap within a few hundred cycles. The same-cycle collisions between an event and a clear, and between a counter read and an increment, are driven directly on both counters.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    // Word offsets of the decoded registers
    localparam int OFF_STATUS  = 0;
    localparam int OFF_MASK    = 1;
    localparam int OFF_UNMASK  = 2;
    localparam int OFF_DOMASK  = 3;
    localparam int OFF_SRC_CNT = 4;
    localparam int OFF_DST_CNT = 5;
    localparam int OFF_LAST    = OFF_DST_CNT;

    // Status bit positions that the unit itself drives
    localparam int BIT_BAD_ACC  = 0;
    localparam int BIT_SRC_DONE = 1;
    localparam int BIT_DST_DONE = 2;
    localparam int BIT_SRC_WRAP = 4;
    localparam int BIT_DST_WRAP = 5;

    typedef struct packed {
        logic st_clr;
        logic unmask_wr;
        logic domask_wr;
        logic src_rd;
        logic dst_rd;
        logic bad;
    } acc_dec_t;

    function automatic logic off_known(input int off);
        return (off >= 0) && (off <= OFF_LAST);
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_dec_t          dec_o
);
    int  off;
    logic wr, rd;

    always_comb begin
        off = int'(bus_addr);
        wr  = bus_valid && bus_write;
        rd  = bus_valid && !bus_write;
        dec_o.st_clr    = wr && (off == OFF_STATUS);
        dec_o.unmask_wr = wr && (off == OFF_UNMASK);
        dec_o.domask_wr = wr && (off == OFF_DOMASK);
        dec_o.src_rd    = rd && (off == OFF_SRC_CNT);
        dec_o.dst_rd    = rd && (off == OFF_DST_CNT);
        dec_o.bad       = bus_valid && !off_known(off);
    end
endmodule

// File: rtl/irq_acct_counter.sv
module irq_acct_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q, base, nxt;

    always_comb begin
        base   = clr_i ? '0 : cnt_q;
        nxt    = base + CNT_W'(inc_i);
        wrap_o = inc_i && !clr_i && (&cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= nxt;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask #(
    parameter int ST_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_i,
    input  logic [ST_W-1:0] clr_i,
    input  logic [ST_W-1:0] unmask_i,
    input  logic [ST_W-1:0] domask_i,
    output logic [ST_W-1:0] status_o,
    output logic [ST_W-1:0] mask_o,
    output logic            irq_o
);
    logic [ST_W-1:0] status_q, mask_q;
    logic            irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '1;
            irq_q    <= 1'b0;
        end else begin
            // a set in the same cycle overrides a clear
            status_q <= (status_q & ~clr_i) | set_i;
            mask_q   <= (mask_q & ~unmask_i) | domask_i;
            irq_q    <= |(status_q & ~mask_q);
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int ST_W   = 12,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ST_W-1:0]   evt_i,
    input  logic              src_done_i,
    input  logic              dst_done_i,
    output logic              irq_o
);
    acc_dec_t         dec;
    logic [ST_W-1:0]  set_vec, clr_vec, unmask_vec, domask_vec;
    logic [ST_W-1:0]  status_q, mask_q;
    logic [CNT_W-1:0] src_cnt, dst_cnt;
    logic             src_wrap, dst_wrap;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .dec_o     (dec)
    );

    irq_acct_counter #(.CNT_W(CNT_W)) u_src_cnt (
        .clk(clk), .rst(rst), .inc_i(src_done_i), .clr_i(dec.src_rd),
        .cnt_o(src_cnt), .wrap_o(src_wrap)
    );

    irq_acct_counter #(.CNT_W(CNT_W)) u_dst_cnt (
        .clk(clk), .rst(rst), .inc_i(dst_done_i), .clr_i(dec.dst_rd),
        .cnt_o(dst_cnt), .wrap_o(dst_wrap)
    );

    always_comb begin
        set_vec               = evt_i;
        set_vec[BIT_BAD_ACC]  = set_vec[BIT_BAD_ACC]  | dec.bad;
        set_vec[BIT_SRC_DONE] = set_vec[BIT_SRC_DONE] | src_done_i;
        set_vec[BIT_DST_DONE] = set_vec[BIT_DST_DONE] | dst_done_i;
        set_vec[BIT_SRC_WRAP] = set_vec[BIT_SRC_WRAP] | src_wrap;
        set_vec[BIT_DST_WRAP] = set_vec[BIT_DST_WRAP] | dst_wrap;
        clr_vec    = {ST_W{dec.st_clr}}    & bus_wdata[ST_W-1:0];
        unmask_vec = {ST_W{dec.unmask_wr}} & bus_wdata[ST_W-1:0];
        domask_vec = {ST_W{dec.domask_wr}} & bus_wdata[ST_W-1:0];
    end

    irq_status_mask #(.ST_W(ST_W)) u_stm (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .unmask_i (unmask_vec),
        .domask_i (domask_vec),
        .status_o (status_q),
        .mask_o   (mask_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (int'(bus_addr))
                OFF_STATUS:  bus_rdata[ST_W-1:0]  = status_q;
                OFF_MASK:    bus_rdata[ST_W-1:0]  = mask_q;
                OFF_SRC_CNT: bus_rdata[CNT_W-1:0] = src_cnt;
                OFF_DST_CNT: bus_rdata[CNT_W-1:0] = dst_cnt;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int ST_W   = 12,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [ST_W-1:0]   evt_i,
    input logic              src_done_i,
    input logic [ST_W-1:0]   status_q,
    input logic [ST_W-1:0]   mask_q,
    input logic [CNT_W-1:0]  src_cnt,
    input logic              irq_o
);
    logic unk;
    assign unk = !off_known(int'(bus_addr));

    // R2
    event_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && int'(bus_addr) == OFF_STATUS) |-> (bus_rdata[DATA_W-1:ST_W] == '0));

    // R3
    unmask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && int'(bus_addr) == OFF_UNMASK)
        |=> ((mask_q & $past(bus_wdata[ST_W-1:0])) == '0));

    // R3
    domask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && int'(bus_addr) == OFF_DOMASK)
        |=> ((mask_q & $past(bus_wdata[ST_W-1:0])) == $past(bus_wdata[ST_W-1:0])));

    // R4
    quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~mask_q) == '0) |=> !irq_o);

    // R6
    src_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (src_done_i && (&src_cnt) && !(bus_valid && !bus_write && int'(bus_addr) == OFF_SRC_CNT))
        |=> status_q[BIT_SRC_WRAP]);

    // R7
    cor_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && int'(bus_addr) == OFF_SRC_CNT && !src_done_i) |=> (src_cnt == '0));

    // R8
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && unk) |-> (bus_rdata == '0));

    // R8
    bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && unk) |=> status_q[BIT_BAD_ACC]);
endmodule

bind dma_irq_unit dma_irq_unit_chk #(
    .ADDR_W(ADDR_W), .ST_W(ST_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .src_done_i(src_done_i), .status_q(status_q),
    .mask_q(mask_q), .src_cnt(src_cnt), .irq_o(irq_o)
);

// File: tb/sim_dma_irq_unit.sv
`timescale 1ns/1ps
module sim_dma_irq_unit;
    localparam int AW = 4;
    localparam int SW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [SW-1:0] evt_i = '0;
    logic          src_done_i = 1'b0, dst_done_i = 1'b0;
    logic          irq_o;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rd;
    logic [31:0] exp_mask;

    always #4 clk = ~clk;

    dma_irq_unit u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .src_done_i(src_done_i), .dst_done_i(dst_done_i),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock cycle with the given inputs; rdata captured before the edge
    task automatic cyc(input logic v, input logic w, input int a, input logic [31:0] d,
                       input logic [SW-1:0] ev, input logic sd, input logic dd,
                       output logic [31:0] r);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = AW'(a); bus_wdata = d;
        evt_i = ev; src_done_i = sd; dst_done_i = dd;
        #1 r = bus_rdata;
        @(posedge clk);
        #1;
        bus_valid = 0; bus_write = 0; evt_i = '0; src_done_i = 0; dst_done_i = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        logic [31:0] r;
        cyc(1, 1, a, d, '0, 0, 0, r);
    endtask

    task automatic rdreg(input int a, output logic [31:0] r);
        cyc(1, 0, a, 0, '0, 0, 0, r);
    endtask

    task automatic pulse_done(input logic src, input int n);
        @(negedge clk);
        if (src) src_done_i = 1; else dst_done_i = 1;
        repeat (n) @(posedge clk);
        #1 src_done_i = 0; dst_done_i = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset values
        chk("R1 irq", {31'b0, irq_o}, 0);
        rdreg(0, r); chk("R1 status", r, 0);
        rdreg(1, r); chk("R1 mask", r, 32'hFFF);
        rdreg(4, r); chk("R1 src cnt", r, 0);
        rdreg(5, r); chk("R1 dst cnt", r, 0);

        // R2 each event bit sets, upper bits zero, W1C clears
        for (int k = 0; k < SW; k++) begin
            cyc(0, 0, 0, 0, SW'(1) << k, 0, 0, r);
            rdreg(0, r); chk("R2 event sets bit", r, 32'h1 << k);
            wr(0, 32'hFFFF_F000 | (32'h1 << k));
            rdreg(0, r); chk("R2 w1c clears", r, 0);
        end

        // R3 unmask progressively, then remask
        exp_mask = 32'hFFF;
        for (int k = 0; k < SW; k++) begin
            wr(2, 32'h1 << k);
            exp_mask &= ~(32'h1 << k);
            rdreg(1, r); chk("R3 unmask", r, exp_mask);
        end
        rdreg(2, r); chk("R3 unmask reads zero", r, 0);
        rdreg(3, r); chk("R3 domask reads zero", r, 0);
        wr(1, 32'hFFF);
        rdreg(1, r); chk("R3 mask offset write ignored", r, 0);
        for (int k = 0; k < SW; k++) begin
            wr(3, 32'h1 << k);
            exp_mask |= (32'h1 << k);
            rdreg(1, r); chk("R3 domask", r, exp_mask);
        end

        // R4 irq follows unmasked status with one register of delay
        for (int k = 0; k < SW; k++) begin
            int j;
            j = (k + 5) % SW;
            wr(2, 32'h1 << k);
            cyc(0, 0, 0, 0, SW'(1) << j, 0, 0, r);
            @(posedge clk); #1;
            chk("R4 masked event no irq", {31'b0, irq_o}, 0);
            cyc(0, 0, 0, 0, SW'(1) << k, 0, 0, r);
            chk("R4 irq not yet", {31'b0, irq_o}, 0);
            @(posedge clk); #1;
            chk("R4 irq rises", {31'b0, irq_o}, 1);
            wr(0, 32'h1 << k);
            chk("R4 irq still high", {31'b0, irq_o}, 1);
            @(posedge clk); #1;
            chk("R4 irq falls", {31'b0, irq_o}, 0);
            wr(3, 32'h1 << k);
            wr(0, 32'hFFF);
        end

        // R5 R6 R7 for both counters
        for (int s = 0; s < 2; s++) begin
            int off, dbit, wbit;
            off  = s ? 4 : 5;
            dbit = s ? 1 : 2;
            wbit = s ? 4 : 5;
            wr(0, 32'hFFF);
            pulse_done(s[0], 10);
            rdreg(off, r); chk("R5 count", r, 10);
            rdreg(0, r);   chk("R5 done bit", r, 32'h1 << dbit);
            rdreg(off, r); chk("R7 clear on read", r, 0);
            pulse_done(s[0], 3);
            wr(off, 32'hFF);
            rdreg(off, r); chk("R7 write ignored", r, 3);
            wr(0, 32'hFFF);
            pulse_done(s[0], 255);
            rdreg(0, r);   chk("R6 no wrap at 255", r, 32'h1 << dbit);
            pulse_done(s[0], 1);
            rdreg(0, r);   chk("R6 wrap flag", r, (32'h1 << dbit) | (32'h1 << wbit));
            rdreg(off, r); chk("R6 wrapped to zero", r, 0);
            // R10 read and increment together
            pulse_done(s[0], 5);
            cyc(1, 0, off, 0, '0, s[0], !s[0], r);
            chk("R10 read returns old", r, 5);
            rdreg(off, r); chk("R10 counter becomes one", r, 1);
        end

        // R8 undecoded offsets
        for (int a = 6; a < 16; a++) begin
            wr(0, 32'hFFF);
            rdreg(a, r); chk("R8 read zero", r, 0);
            rdreg(0, r); chk("R8 flag on read", r, 1);
            wr(0, 32'h1);
            wr(a, 32'hFFFF_FFFF);
            rdreg(0, r); chk("R8 flag on write", r, 1);
        end

        // R9 event beats simultaneous clear
        wr(0, 32'hFFF);
        cyc(1, 0, 0, 0, SW'(12'h008), 0, 0, r);
        cyc(1, 1, 0, 32'h008, SW'(12'h008), 0, 0, r);
        rdreg(0, r); chk("R9 event wins", r, 32'h008);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule